// File: doc/BRIEF.md
# Log-Size to Byte-Lane Data Aligner

This block sits in the system interconnect, between a load/store unit and a memory or bus that uses one write enable per byte lane. The load/store unit states each access size as a logarithm: 0 is one byte, 1 is two bytes and 2 is four bytes. It always keeps its operand in the low-order bytes of a register. On the request side, the aligner takes the low address bits and the log-size and turns them into lane enables. For a write, it also moves the operand bytes onto the lanes that the address selects. Both request outputs are combinational from the request inputs.

Read data comes back a fixed `DLY` cycles after the request. The aligner keeps one lane-select register per result byte and delays the selects to match. When the data arrives, the selected lanes are folded back into the low-order result bytes. A result byte that the current read does not cover keeps its old select, so its multiplexer does not toggle.

A per-request order bit picks little-endian or big-endian placement. A request whose byte span would run past the bus word is rejected: it raises an error flag and drives no enables.

Top module: `lsz_lane_aligner`

## Requirements
- R1: For a valid request that fits, `mem_req` is high and lane i of `mem_ben` is high exactly when ofs <= i < ofs + 2^size, for both reads and writes. With `req_vld` low, `mem_req` is low and `mem_ben` is all zero.
- R2: A valid request with size > log2(BUS_BYTES), or with ofs + 2^size > BUS_BYTES, raises `req_err`. It drives `mem_req`, `mem_we` and `mem_ben` to zero. It changes neither the held write lanes nor the read selects.
- R3: With order 0 (little endian), an enabled write lane i carries operand byte (i - ofs), where byte 0 is bits 7:0 of `req_wdata`.
- R4: With order 1 (big endian), an enabled write lane i carries operand byte (ofs + 2^size - 1 - i).
- R5: Every lane not written by the current request carries the value that the last accepted write drove on that lane. This holds for reads and idle cycles too. After reset every lane holds zero.
- R6: `rsp_vld` is high exactly DLY cycles after an accepted read (fitting, `req_wr` low), and is low otherwise.
- R7: For a little-endian read, result byte k (k < 2^size) in the response cycle equals `mem_rdata` lane (ofs + k).
- R8: For a big-endian read, result byte k (k < 2^size) equals `mem_rdata` lane (ofs + 2^size - 1 - k).
- R9: A result byte not covered by the latest read keeps the lane select of the most recent read that did cover it. After reset, byte k selects lane k. `rsp_rdata` is always driven through these selects from the current `mem_rdata`.
- R10: `mem_we` is high exactly when `req_vld` and `req_wr` are high and the request fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_order | input | 1 | 0 = little endian, 1 = big endian |
| req_ofs | input | log2(BUS_BYTES) | Byte offset within the bus word |
| req_size | input | clog2(log2(BUS_BYTES)+1) | log2 of the access size in bytes |
| req_wdata | input | 8*BUS_BYTES | Write operand, low-order aligned |
| req_err | output | 1 | Request span does not fit in the word |
| mem_req | output | 1 | Accepted request towards memory |
| mem_we | output | 1 | Accepted write towards memory |
| mem_ben | output | BUS_BYTES | Per-lane byte enables |
| mem_wdata | output | 8*BUS_BYTES | Lane-positioned write data |
| mem_rdata | input | 8*BUS_BYTES | Lane-positioned read data from memory |
| rsp_vld | output | 1 | Read response cycle |
| rsp_rdata | output | 8*BUS_BYTES | Read result, low-order aligned |

## Verification
The assertions check every cycle that an error request gates off all enables, and that the number of enabled lanes equals 2^size. They also check that a write only happens as an accepted write, that the write lanes stay frozen between writes, and that the response flag follows an accepted read by exactly DLY cycles. Lane-by-lane placement in both byte orders, and the folding of read lanes back into result bytes, depend on stimulus history. So do the frozen selects of uncovered result bytes. Only the bench's random and directed scenarios can show these, checked against its own model.

// File: rtl/lsz_pkg.sv
package lsz_pkg;

    typedef enum logic {
        ORD_LITTLE = 1'b0,
        ORD_BIG    = 1'b1
    } byte_order_e;

    typedef struct packed {
        logic ok;
        logic wr_ok;
        logic rd_ok;
    } req_cls_t;

    // Number of bytes covered by a log-encoded size.
    function automatic int span_bytes(input int sz);
        return 1 << sz;
    endfunction

    // True when the span starting at ofs stays inside the bus word.
    function automatic logic span_fits(input int ofs, input int sz,
                                       input int nbytes, input int log_nb);
        if (sz > log_nb) return 1'b0;
        return (ofs + span_bytes(sz)) <= nbytes;
    endfunction

    // Lane that holds operand byte k for the given placement.
    function automatic int lane_of(input int k, input int ofs, input int sz,
                                   input byte_order_e ord);
        if (ord == ORD_BIG) return ofs + span_bytes(sz) - 1 - k;
        return ofs + k;
    endfunction

    function automatic logic lane_covered(input int lane, input int ofs,
                                          input int sz);
        return (lane >= ofs) && (lane < ofs + span_bytes(sz));
    endfunction

endpackage

// File: rtl/lsz_req_decode.sv
module lsz_req_decode
    import lsz_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    localparam int LOG_BB = $clog2(BUS_BYTES),
    localparam int SIZE_W = $clog2(LOG_BB + 1)
) (
    input  logic                 vld,
    input  logic                 wr,
    input  logic [LOG_BB-1:0]    ofs,
    input  logic [SIZE_W-1:0]    size,
    output req_cls_t             cls,
    output logic                 err,
    output logic [BUS_BYTES-1:0] lane_en
);

    logic fits;

    always_comb begin
        fits      = span_fits(int'(ofs), int'(size), BUS_BYTES, LOG_BB);
        err       = vld && !fits;
        cls.ok    = vld && fits;
        cls.wr_ok = vld && fits && wr;
        cls.rd_ok = vld && fits && !wr;
    end

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        assign lane_en[i] = cls.ok && lane_covered(i, int'(ofs), int'(size));
    end

endmodule

// File: rtl/lsz_wr_steer.sv
module lsz_wr_steer
    import lsz_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    localparam int LOG_BB = $clog2(BUS_BYTES),
    localparam int SIZE_W = $clog2(LOG_BB + 1),
    localparam int DW     = 8 * BUS_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  req_cls_t             cls,
    input  logic [LOG_BB-1:0]    ofs,
    input  logic [SIZE_W-1:0]    size,
    input  byte_order_e          order,
    input  logic [BUS_BYTES-1:0] lane_en,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        lane_data
);

    logic [DW-1:0] hold_q;

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        always_comb begin
            lane_data[8*i +: 8] = hold_q[8*i +: 8];
            if (cls.wr_ok && lane_en[i]) begin
                for (int k = 0; k < BUS_BYTES; k++) begin
                    if (k < span_bytes(int'(size)) &&
                        lane_of(k, int'(ofs), int'(size), order) == i) begin
                        lane_data[8*i +: 8] = wdata[8*k +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (cls.wr_ok) begin
            hold_q <= lane_data;
        end
    end

endmodule

// File: rtl/lsz_rd_align.sv
module lsz_rd_align
    import lsz_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int DLY       = 1,
    localparam int LOG_BB = $clog2(BUS_BYTES),
    localparam int SIZE_W = $clog2(LOG_BB + 1),
    localparam int SEL_W  = LOG_BB,
    localparam int DW     = 8 * BUS_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  req_cls_t          cls,
    input  logic [LOG_BB-1:0] ofs,
    input  logic [SIZE_W-1:0] size,
    input  byte_order_e       order,
    input  logic [DW-1:0]     mem_rdata,
    output logic              rsp_vld,
    output logic [DW-1:0]     rsp_rdata
);

    typedef logic [BUS_BYTES-1:0][SEL_W-1:0] sel_vec_t;

    sel_vec_t sel_cur, sel_nxt, sel_use;
    logic     rd_q;

    // Only covered result bytes take a new select; the rest stay frozen.
    always_comb begin
        sel_nxt = sel_cur;
        if (cls.rd_ok) begin
            for (int k = 0; k < BUS_BYTES; k++) begin
                if (k < span_bytes(int'(size))) begin
                    sel_nxt[k] = SEL_W'(lane_of(k, int'(ofs), int'(size), order));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < BUS_BYTES; k++) sel_cur[k] <= SEL_W'(k);
            rd_q <= 1'b0;
        end else begin
            sel_cur <= sel_nxt;
            rd_q    <= cls.rd_ok;
        end
    end

    if (DLY == 0) begin : g_dly0
        assign sel_use = sel_nxt;
        assign rsp_vld = cls.rd_ok;
    end else if (DLY == 1) begin : g_dly1
        assign sel_use = sel_cur;
        assign rsp_vld = rd_q;
    end else begin : g_dlyn
        sel_vec_t [DLY-2:0] sel_pipe;
        logic     [DLY-2:0] vld_pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int j = 0; j < DLY - 1; j++) begin
                    for (int k = 0; k < BUS_BYTES; k++) sel_pipe[j][k] <= SEL_W'(k);
                end
                vld_pipe <= '0;
            end else begin
                for (int j = DLY - 2; j > 0; j--) begin
                    sel_pipe[j] <= sel_pipe[j-1];
                    vld_pipe[j] <= vld_pipe[j-1];
                end
                sel_pipe[0] <= sel_cur;
                vld_pipe[0] <= rd_q;
            end
        end
        assign sel_use = sel_pipe[DLY-2];
        assign rsp_vld = vld_pipe[DLY-2];
    end

    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_byte
        assign rsp_rdata[8*k +: 8] = mem_rdata[8*sel_use[k] +: 8];
    end

endmodule

// File: rtl/lsz_lane_aligner.sv
module lsz_lane_aligner
    import lsz_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int DLY       = 1,
    localparam int LOG_BB = $clog2(BUS_BYTES),
    localparam int SIZE_W = $clog2(LOG_BB + 1),
    localparam int DW     = 8 * BUS_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_vld,
    input  logic                 req_wr,
    input  logic                 req_order,
    input  logic [LOG_BB-1:0]    req_ofs,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic [DW-1:0]        req_wdata,
    output logic                 req_err,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [BUS_BYTES-1:0] mem_ben,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    output logic                 rsp_vld,
    output logic [DW-1:0]        rsp_rdata
);

    req_cls_t    cls;
    byte_order_e order;

    assign order = byte_order_e'(req_order);

    lsz_req_decode #(.BUS_BYTES(BUS_BYTES)) u_dec (
        .vld     (req_vld),
        .wr      (req_wr),
        .ofs     (req_ofs),
        .size    (req_size),
        .cls     (cls),
        .err     (req_err),
        .lane_en (mem_ben)
    );

    lsz_wr_steer #(.BUS_BYTES(BUS_BYTES)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .cls       (cls),
        .ofs       (req_ofs),
        .size      (req_size),
        .order     (order),
        .lane_en   (mem_ben),
        .wdata     (req_wdata),
        .lane_data (mem_wdata)
    );

    lsz_rd_align #(.BUS_BYTES(BUS_BYTES), .DLY(DLY)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .cls       (cls),
        .ofs       (req_ofs),
        .size      (req_size),
        .order     (order),
        .mem_rdata (mem_rdata),
        .rsp_vld   (rsp_vld),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_req = cls.ok;
    assign mem_we  = cls.wr_ok;

endmodule

// File: rtl/lsz_lane_aligner_chk.sv
module lsz_lane_aligner_chk #(
    parameter int BUS_BYTES = 4,
    parameter int DLY       = 1,
    localparam int LOG_BB = $clog2(BUS_BYTES),
    localparam int SIZE_W = $clog2(LOG_BB + 1),
    localparam int DW     = 8 * BUS_BYTES
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_vld,
    input logic                 req_wr,
    input logic [SIZE_W-1:0]    req_size,
    input logic                 req_err,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic [BUS_BYTES-1:0] mem_ben,
    input logic [DW-1:0]        mem_wdata,
    input logic                 rsp_vld
);

    logic past_ok;
    logic rd_now;
    logic exp_rsp;

    assign rd_now = mem_req && !req_wr;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    if (DLY == 0) begin : g_h0
        assign exp_rsp = rd_now;
    end else begin : g_hn
        logic [DLY-1:0] hist;
        always_ff @(posedge clk) begin
            if (rst) begin
                hist <= '0;
            end else begin
                for (int j = DLY - 1; j > 0; j--) hist[j] <= hist[j-1];
                hist[0] <= rd_now;
            end
        end
        assign exp_rsp = hist[DLY-1];
    end

    // R2
    err_gate_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (mem_ben == '0 && !mem_req && !mem_we));

    // R1
    ben_count_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_ben) == (32'd1 << req_size)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_vld |-> (mem_ben == '0 && !mem_req));

    // R10
    we_source_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (req_vld && req_wr && !req_err));

    // R5
    wlane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !mem_we && !$past(mem_we)) |-> $stable(mem_wdata));

    // R6
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_vld == exp_rsp);

endmodule

bind lsz_lane_aligner lsz_lane_aligner_chk #(
    .BUS_BYTES (BUS_BYTES),
    .DLY       (DLY)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_vld   (req_vld),
    .req_wr    (req_wr),
    .req_size  (req_size),
    .req_err   (req_err),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ben   (mem_ben),
    .mem_wdata (mem_wdata),
    .rsp_vld   (rsp_vld)
);

// File: tb/lsz_lane_aligner_test.sv
module lsz_lane_aligner_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0, req_wr = 1'b0, req_order = 1'b0;
    logic [1:0]  req_ofs = '0, req_size = '0;
    logic [31:0] req_wdata = '0, mem_rdata = '0;
    logic        req_err, mem_req, mem_we, rsp_vld;
    logic [3:0]  mem_ben;
    logic [31:0] mem_wdata, rsp_rdata;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    // bench model state
    logic [31:0] m_hold;
    int          m_sel [NB];
    bit          m_pend;
    int          m_rn;
    bit          m_rord;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsz_lane_aligner #(.BUS_BYTES(NB), .DLY(1)) uut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr),
        .req_order(req_order), .req_ofs(req_ofs), .req_size(req_size),
        .req_wdata(req_wdata), .req_err(req_err), .mem_req(mem_req),
        .mem_we(mem_we), .mem_ben(mem_ben), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit good, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit fits(input int ofs, input int sz);
        return (sz <= 2) && (ofs + (1 << sz) <= NB);
    endfunction

    // Lane carrying operand byte k (R3/R7 little, R4/R8 big)
    function automatic int place(input int k, input int ofs, input int sz, input bit big);
        return big ? (ofs + (1 << sz) - 1 - k) : (ofs + k);
    endfunction

    task automatic step(input bit vld, input bit wr, input bit big,
                        input int ofs, input int sz, input logic [31:0] wd);
        bit          ok;
        int          n;
        logic [3:0]  e_ben;
        logic [31:0] e_wd, e_rd, amask;
        @(negedge clk);
        req_vld = vld; req_wr = wr; req_order = big;
        req_ofs = 2'(ofs); req_size = 2'(sz); req_wdata = wd;
        mem_rdata = $urandom;
        #1;
        ok = vld && fits(ofs, sz);
        n = 1 << sz;
        e_ben = '0;
        e_wd = m_hold;
        if (ok) begin
            for (int i = 0; i < NB; i++) e_ben[i] = (i >= ofs) && (i < ofs + n);
            if (wr) begin
                for (int k = 0; k < n; k++) e_wd[8*place(k, ofs, sz, big) +: 8] = wd[8*k +: 8];
            end
        end
        chk(req_err == (vld && !ok), "R2 req_err", 32'(req_err), 32'(vld && !ok));
        chk(mem_req == ok, "R1 mem_req", 32'(mem_req), 32'(ok));
        chk(mem_we == (ok && wr), "R10 mem_we", 32'(mem_we), 32'(ok && wr));
        chk(mem_ben == e_ben, (vld && !ok) ? "R2 mem_ben" : "R1 mem_ben",
            32'(mem_ben), 32'(e_ben));
        chk(mem_wdata == e_wd, !(ok && wr) ? "R5 mem_wdata" : (big ? "R4 mem_wdata" : "R3 mem_wdata"),
            mem_wdata, e_wd);
        chk(rsp_vld == m_pend, "R6 rsp_vld", 32'(rsp_vld), 32'(m_pend));
        for (int k = 0; k < NB; k++) e_rd[8*k +: 8] = mem_rdata[8*m_sel[k] +: 8];
        amask = '0;
        for (int k = 0; k < m_rn; k++) amask[8*k +: 8] = 8'hff;
        if (m_rn > 0)
            chk((rsp_rdata & amask) == (e_rd & amask), m_rord ? "R8 rsp_rdata" : "R7 rsp_rdata",
                rsp_rdata & amask, e_rd & amask);
        chk((rsp_rdata & ~amask) == (e_rd & ~amask), "R9 rsp_rdata",
            rsp_rdata & ~amask, e_rd & ~amask);
        @(posedge clk);
        if (ok && wr) m_hold = e_wd;
        if (ok && !wr) begin
            for (int k = 0; k < n; k++) m_sel[k] = place(k, ofs, sz, big);
            m_rn = n;
            m_rord = big;
        end else begin
            m_rn = 0;
        end
        m_pend = ok && !wr;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_hold = '0;
        for (int k = 0; k < NB; k++) m_sel[k] = k;
        m_pend = 0; m_rn = 0; m_rord = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state: zero write lanes (R5), no response (R6), identity selects (R9)
        step(0, 0, 0, 0, 0, 32'h0);
        // directed corners
        step(1, 1, 1, 0, 2, 32'h11223344);   // R4 full word big endian
        step(1, 1, 0, 3, 0, 32'hdeadbeaa);   // R3 top byte, R5 other lanes kept
        step(1, 1, 1, 2, 1, 32'h0000c0de);   // R4 half at upper lanes
        step(1, 1, 0, 3, 1, 32'h12345678);   // R2 half past word end
        step(1, 0, 0, 1, 2, 32'h0);          // R2 misplaced word read
        step(1, 1, 0, 0, 3, 32'hffffffff);   // R2 size beyond bus
        step(1, 0, 1, 3, 0, 32'h0);          // R8 byte read
        step(1, 0, 0, 2, 1, 32'h0);          // R7 half read, R9 upper bytes frozen
        step(1, 0, 1, 0, 2, 32'h0);          // R8 word read
        step(0, 0, 0, 0, 0, 32'h0);          // R6 idle after read
        for (int t = 0; t < 600; t++) begin
            step(($urandom % 5) != 0, $urandom % 2, $urandom % 2,
                 $urandom % 4, $urandom % 4, $urandom);
        end
        step(0, 0, 0, 0, 0, 32'h0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule